// File: doc/BRIEF.md
# Video Sync Timing Analyzer

This block watches the horizontal sync, vertical sync and data-enable signals of a video stream on the shared pixel clock and works out the frame's timing. It reports porch and sync widths in both dimensions, the active width and height, and the polarity of each sync. It also gives the live position of the pixel being received. A timing regenerator further down the pipeline uses these values to build a modified output raster, for example one that is twice as wide for side-by-side stereo.

Each sync is first brought to an active-high form. The polarity is taken as the level that fills the shorter part of its period. A horizontal counter restarts on the leading edge of the line sync. A line counter advances once per line and restarts when the vertical sync, sampled at the start of a line, rises. Measurements pass to the outputs only at a frame boundary. A lock flag is raised once two clean frames in a row give identical values.

The lock controller has four states. SEEK waits for the first frame boundary after reset. FIRST measures a frame that has no trusted predecessor. CHECK compares a frame with the one before it. LOCK holds the flag high. The transitions are: SEEK to FIRST on a frame boundary. FIRST to CHECK on a frame boundary. CHECK to LOCK on a boundary whose values match the stored set. LOCK to CHECK on a boundary whose values differ. Any state other than SEEK goes to FIRST when a position counter saturates.

Top module: `vid_timing_probe`

## Requirements
- R1: After reset every measurement output, both polarity outputs, `h_pos`, `v_pos` and `timing_valid` are 0.
- R2: `hs_pol`/`vs_pol` read 1 when the sync is active-high and 0 when it is active-low. The active level is the one whose run is shorter. While `timing_valid` stays high, neither polarity output changes.
- R3: `h_sync_w`, `h_bporch` and `h_fporch` give, in pixel clocks, the sync length, the gap from sync end to the first DE-high pixel, and the gap from the last DE-high pixel to the next sync leading edge.
- R4: `h_active` is the number of DE-high pixels in the last line of the frame that carried DE.
- R5: `v_sync_w`, `v_bporch` and `v_fporch` give, in lines, the vertical sync length, the lines from sync end to the first line with DE, and the lines from the last DE line to the next vertical leading edge. Vertical sync is sampled at each line's leading edge.
- R6: `v_active` is the count of lines from the first to the last line with DE in the frame.
- R7: `h_pos` is the pixel index since the normalised line-sync leading edge, where the first sync pixel is 0. `v_pos` is the line index since the vertical leading edge. Both belong to the input sample taken two clock edges earlier.
- R8: Measurement and polarity outputs change only on the clock edge that follows a frame boundary.
- R9: `timing_valid` rises only at a frame boundary. It needs two consecutive full, saturation-free frames with identical values. It falls at the first boundary whose frame differs.
- R10: Position counters saturate at 4095. A saturated counter clears `timing_valid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Line sync, either polarity |
| vs_in | input | 1 | Frame sync, either polarity |
| de_in | input | 1 | Data enable, active-high |
| h_sync_w | output | 12 | Line sync width, pixels |
| h_bporch | output | 12 | Horizontal back porch, pixels |
| h_active | output | 12 | Active pixels per line |
| h_fporch | output | 12 | Horizontal front porch, pixels |
| v_sync_w | output | 12 | Frame sync width, lines |
| v_bporch | output | 12 | Vertical back porch, lines |
| v_active | output | 12 | Active lines per frame |
| v_fporch | output | 12 | Vertical front porch, lines |
| hs_pol | output | 1 | 1 = line sync active-high |
| vs_pol | output | 1 | 1 = frame sync active-high |
| h_pos | output | 12 | Current pixel index in line |
| v_pos | output | 12 | Current line index in frame |
| timing_valid | output | 1 | Two matching frames seen |

## Verification
On every cycle, the checker confirms four things. The outputs move only after a frame boundary. The lock flag rises only at a boundary. Polarity holds while locked. Saturation drops the lock. It also confirms that the pixel index either steps by one or restarts at zero. The exact widths, the polarity decision for each mix of sync levels, the two-frame lock latency, the loss of lock after a change in geometry, and the relock after a long sync outage can only be shown by the bench. It drives known rasters and compares position and measurements against its own model on each clock.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
    localparam int unsigned DEF_CW = 12;

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_FIRST,
        ST_CHECK,
        ST_LOCK
    } lock_st_e;
endpackage

// File: rtl/vtp_pol.sv
module vtp_pol #(
    parameter int unsigned CW = vtp_pkg::DEF_CW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pol_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          prev_q, armed_q, seen_hi_q, seen_lo_q;
    logic [CW-1:0] run_q, hi_len_q, lo_len_q;

    // A run is recorded only once an edge has been seen, so the partial
    // run in progress at reset never decides the polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            armed_q   <= 1'b0;
            seen_hi_q <= 1'b0;
            seen_lo_q <= 1'b0;
            run_q     <= '0;
            hi_len_q  <= '0;
            lo_len_q  <= '0;
        end else begin
            prev_q <= lvl_i;
            if (lvl_i != prev_q) begin
                run_q   <= CW'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    if (prev_q) begin
                        hi_len_q  <= run_q;
                        seen_hi_q <= 1'b1;
                    end else begin
                        lo_len_q  <= run_q;
                        seen_lo_q <= 1'b1;
                    end
                end
            end else if (run_q != MAXV) begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    assign pol_o = (seen_hi_q && seen_lo_q) ? (hi_len_q < lo_len_q) : 1'b1;
endmodule

// File: rtl/vtp_hmeas.sv
module vtp_hmeas #(
    parameter int unsigned CW = vtp_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nhs_i,
    input  logic          de_i,
    output logic          hs_lead_o,
    output logic          line_de_o,
    output logic          sat_o,
    output logic [CW-1:0] pos_o,
    output logic [CW-1:0] sync_o,
    output logic [CW-1:0] bp_o,
    output logic [CW-1:0] act_o,
    output logic [CW-1:0] fp_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          nhs_p, de_p, had_de, got_end, got_rise;
    logic [CW-1:0] hcnt, hidx, tot, sync_end, de_rise, de_fall;

    assign hs_lead_o = nhs_i & ~nhs_p;
    assign tot       = (hcnt == MAXV) ? MAXV : hcnt + CW'(1);
    assign hidx      = hs_lead_o ? '0 : tot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nhs_p    <= 1'b0;
            de_p     <= 1'b0;
            had_de   <= 1'b0;
            got_end  <= 1'b0;
            got_rise <= 1'b0;
            hcnt     <= '0;
            sync_end <= '0;
            de_rise  <= '0;
            de_fall  <= '0;
            sync_o   <= '0;
            bp_o     <= '0;
            act_o    <= '0;
            fp_o     <= '0;
        end else begin
            nhs_p <= nhs_i;
            de_p  <= de_i;
            hcnt  <= hidx;
            if (hs_lead_o) begin
                had_de   <= 1'b0;
                got_end  <= 1'b0;
                got_rise <= 1'b0;
                if (had_de) begin
                    sync_o <= sync_end;
                    bp_o   <= de_rise - sync_end;
                    act_o  <= de_fall - de_rise;
                    fp_o   <= tot - de_fall;
                end
            end else begin
                if (!nhs_i && nhs_p && !got_end) begin
                    sync_end <= hidx;
                    got_end  <= 1'b1;
                end
                if (de_i && !de_p && !got_rise) begin
                    de_rise  <= hidx;
                    got_rise <= 1'b1;
                    had_de   <= 1'b1;
                end
                if (!de_i && de_p) begin
                    de_fall <= hidx;
                end
            end
        end
    end

    assign line_de_o = had_de;
    assign sat_o     = (hcnt == MAXV);
    assign pos_o     = hcnt;
endmodule

// File: rtl/vtp_vmeas.sv
module vtp_vmeas #(
    parameter int unsigned CW = vtp_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_lead_i,
    input  logic          nvs_i,
    input  logic          line_de_i,
    output logic          frame_end_o,
    output logic          sat_o,
    output logic [CW-1:0] pos_o,
    output logic [CW-1:0] sync_o,
    output logic [CW-1:0] bp_o,
    output logic [CW-1:0] act_o,
    output logic [CW-1:0] fp_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          vs_line, seen_act;
    logic [CW-1:0] vcnt, vnext, vidx, vs_end, first_act, act_end, fa_eff, ae_eff;

    assign frame_end_o = hs_lead_i & nvs_i & ~vs_line;
    assign vnext       = (vcnt == MAXV) ? MAXV : vcnt + CW'(1);
    assign vidx        = hs_lead_i ? (frame_end_o ? '0 : vnext) : vcnt;

    // The line that ends at a frame boundary is folded in combinationally.
    assign fa_eff = (line_de_i && !seen_act) ? vcnt : first_act;
    assign ae_eff = line_de_i ? vnext : act_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_line   <= 1'b0;
            seen_act  <= 1'b0;
            vcnt      <= '0;
            vs_end    <= '0;
            first_act <= '0;
            act_end   <= '0;
        end else begin
            vcnt <= vidx;
            if (hs_lead_i) begin
                vs_line <= nvs_i;
                if (frame_end_o) begin
                    seen_act <= 1'b0;
                end else begin
                    if (line_de_i) begin
                        if (!seen_act) begin
                            first_act <= vcnt;
                            seen_act  <= 1'b1;
                        end
                        act_end <= vnext;
                    end
                    if (!nvs_i && vs_line) begin
                        vs_end <= vidx;
                    end
                end
            end
        end
    end

    assign sync_o = vs_end;
    assign bp_o   = fa_eff - vs_end;
    assign act_o  = ae_eff - fa_eff;
    assign fp_o   = vnext - ae_eff;
    assign sat_o  = (vcnt == MAXV);
    assign pos_o  = vcnt;
endmodule

// File: rtl/vid_timing_probe.sv
module vid_timing_probe #(
    parameter int unsigned CW = vtp_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_in,
    input  logic          vs_in,
    input  logic          de_in,
    output logic [CW-1:0] h_sync_w,
    output logic [CW-1:0] h_bporch,
    output logic [CW-1:0] h_active,
    output logic [CW-1:0] h_fporch,
    output logic [CW-1:0] v_sync_w,
    output logic [CW-1:0] v_bporch,
    output logic [CW-1:0] v_active,
    output logic [CW-1:0] v_fporch,
    output logic          hs_pol,
    output logic          vs_pol,
    output logic [CW-1:0] h_pos,
    output logic [CW-1:0] v_pos,
    output logic          timing_valid
);
    import vtp_pkg::*;

    localparam int unsigned NSYNC = 2;
    localparam int unsigned PW    = 8 * CW + 2;

    logic [NSYNC-1:0] sync_q, pol, nsync;
    logic             de_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            de_q   <= 1'b0;
        end else begin
            sync_q <= {vs_in, hs_in};
            de_q   <= de_in;
        end
    end

    for (genvar g = 0; g < NSYNC; g++) begin : g_pol
        vtp_pol #(.CW(CW)) u_pol (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (sync_q[g]),
            .pol_o (pol[g])
        );
        assign nsync[g] = pol[g] ? sync_q[g] : ~sync_q[g];
    end

    logic          hs_lead, line_de, h_sat, v_sat, frame_end;
    logic [CW-1:0] hs_w, hb, ha, hf, vsw, vb, va, vf;

    vtp_hmeas #(.CW(CW)) u_hmeas (
        .clk       (clk),
        .rst_n     (rst_n),
        .nhs_i     (nsync[0]),
        .de_i      (de_q),
        .hs_lead_o (hs_lead),
        .line_de_o (line_de),
        .sat_o     (h_sat),
        .pos_o     (h_pos),
        .sync_o    (hs_w),
        .bp_o      (hb),
        .act_o     (ha),
        .fp_o      (hf)
    );

    vtp_vmeas #(.CW(CW)) u_vmeas (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_lead_i   (hs_lead),
        .nvs_i       (nsync[1]),
        .line_de_i   (line_de),
        .frame_end_o (frame_end),
        .sat_o       (v_sat),
        .pos_o       (v_pos),
        .sync_o      (vsw),
        .bp_o        (vb),
        .act_o       (va),
        .fp_o        (vf)
    );

    logic [PW-1:0] cand, held;
    logic          match, sat_any;

    assign cand    = {hs_w, hb, ha, hf, vsw, vb, va, vf, pol[0], pol[1]};
    assign held    = {h_sync_w, h_bporch, h_active, h_fporch,
                      v_sync_w, v_bporch, v_active, v_fporch, hs_pol, vs_pol};
    assign match   = (cand == held);
    assign sat_any = h_sat | v_sat;

    lock_st_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SEEK:  if (frame_end) state_n = ST_FIRST;
            ST_FIRST: if (sat_any) state_n = ST_FIRST;
                      else if (frame_end) state_n = ST_CHECK;
            ST_CHECK: if (sat_any) state_n = ST_FIRST;
                      else if (frame_end && match) state_n = ST_LOCK;
            ST_LOCK:  if (sat_any) state_n = ST_FIRST;
                      else if (frame_end && !match) state_n = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_valid <= 1'b0;
            {h_sync_w, h_bporch, h_active, h_fporch,
             v_sync_w, v_bporch, v_active, v_fporch, hs_pol, vs_pol} <= '0;
        end else begin
            timing_valid <= (state_n == ST_LOCK);
            if (frame_end && state_q != ST_SEEK) begin
                {h_sync_w, h_bporch, h_active, h_fporch,
                 v_sync_w, v_bporch, v_active, v_fporch, hs_pol, vs_pol} <= cand;
            end
        end
    end
endmodule

// File: rtl/vtp_chk.sv
module vtp_chk #(
    parameter int unsigned CW = vtp_pkg::DEF_CW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_end,
    input logic            timing_valid,
    input logic            hs_pol,
    input logic            vs_pol,
    input logic [CW-1:0]   h_pos,
    input logic [CW-1:0]   v_pos,
    input logic [8*CW-1:0] meas
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    // R8
    meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(meas) && $stable(hs_pol) && $stable(vs_pol)));

    // R9
    lock_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_valid) |-> $past(frame_end));

    // R10
    sat_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == MAXV || v_pos == MAXV) |=> !timing_valid);

    // R2
    pol_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_valid && $past(timing_valid)) |-> ($stable(hs_pol) && $stable(vs_pol)));

    // R7
    hpos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != MAXV) |=> (h_pos == $past(h_pos) + CW'(1) || h_pos == '0));
endmodule

bind vid_timing_probe vtp_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .timing_valid (timing_valid),
    .hs_pol       (hs_pol),
    .vs_pol       (vs_pol),
    .h_pos        (h_pos),
    .v_pos        (v_pos),
    .meas         ({h_sync_w, h_bporch, h_active, h_fporch,
                    v_sync_w, v_bporch, v_active, v_fporch})
);

// File: tb/vid_timing_probe_tb.sv
module vid_timing_probe_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
    logic [11:0] h_sync_w, h_bporch, h_active, h_fporch;
    logic [11:0] v_sync_w, v_bporch, v_active, v_fporch;
    logic [11:0] h_pos, v_pos;
    logic hs_pol, vs_pol, timing_valid;

    always #2 clk = ~clk;

    vid_timing_probe u_dut (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
        .h_sync_w(h_sync_w), .h_bporch(h_bporch), .h_active(h_active), .h_fporch(h_fporch),
        .v_sync_w(v_sync_w), .v_bporch(v_bporch), .v_active(v_active), .v_fporch(v_fporch),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .h_pos(h_pos), .v_pos(v_pos),
        .timing_valid(timing_valid)
    );

    int n_chk = 0, n_fail = 0;
    int g_hs, g_hb, g_ha, g_hf, g_vs, g_vb, g_va, g_vf;
    bit g_hpol, g_vpol;
    int cur_h = 0, cur_v = 0;
    int hh0 = 0, hh1 = 0, hh2 = 0, vh0 = 0, vh1 = 0, vh2 = 0, hist_n = 0;
    bit cmp_meas = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_geom(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf,
                            bit hp, bit vp);
        g_hs = hs; g_hb = hb; g_ha = ha; g_hf = hf;
        g_vs = vs; g_vb = vb; g_va = va; g_vf = vf;
        g_hpol = hp; g_vpol = vp;
    endtask

    task automatic drive_px(int h, int v);
        bit hsy, vsy, act;
        hsy = (h < g_hs);
        vsy = (v < g_vs);
        act = (v >= g_vs + g_vb) && (v < g_vs + g_vb + g_va) &&
              (h >= g_hs + g_hb) && (h < g_hs + g_hb + g_ha);
        @(posedge clk); #1;
        hs_in = g_hpol ? hsy : !hsy;
        vs_in = g_vpol ? vsy : !vsy;
        de_in = act;
        cur_h = h; cur_v = v;
    endtask

    task automatic send_frame();
        for (int v = 0; v < g_vs + g_vb + g_va + g_vf; v++)
            for (int h = 0; h < g_hs + g_hb + g_ha + g_hf; h++)
                drive_px(h, v);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            hs_in = !g_hpol; vs_in = !g_vpol; de_in = 1'b0;
            cur_h = (cur_h < 4095) ? cur_h + 1 : 4095;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hs_in = !g_hpol; vs_in = !g_vpol; de_in = 1'b0;
        cur_h = 0; cur_v = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic check_all(string tag);
        chk({tag, " R3 h_sync"}, h_sync_w, g_hs);
        chk({tag, " R3 h_bporch"}, h_bporch, g_hb);
        chk({tag, " R3 h_fporch"}, h_fporch, g_hf);
        chk({tag, " R4 h_active"}, h_active, g_ha);
        chk({tag, " R5 v_sync"}, v_sync_w, g_vs);
        chk({tag, " R5 v_bporch"}, v_bporch, g_vb);
        chk({tag, " R5 v_fporch"}, v_fporch, g_vf);
        chk({tag, " R6 v_active"}, v_active, g_va);
        chk({tag, " R2 hs_pol"}, hs_pol, g_hpol);
        chk({tag, " R2 vs_pol"}, vs_pol, g_vpol);
    endtask

    task automatic wait_lock(int max_frames);
        for (int i = 0; i < max_frames; i++) begin
            if (timing_valid) break;
            send_frame();
        end
        @(negedge clk);
    endtask

    // Reference model: positions lag the driven pixel by two clock edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            hist_n = 0;
        end else begin
            hh2 = hh1; hh1 = hh0; hh0 = cur_h;
            vh2 = vh1; vh1 = vh0; vh0 = cur_v;
            if (hist_n < 3) hist_n++;
            if (hist_n >= 3 && timing_valid && !done) begin
                chk("R7 h_pos", h_pos, hh2);
                chk("R7 v_pos", v_pos, vh2);
                if (cmp_meas) begin
                    // R8: held values equal the stream geometry every cycle
                    chk("R8 h_active", h_active, g_ha);
                    chk("R8 v_active", v_active, g_va);
                    chk("R8 h_sync", h_sync_w, g_hs);
                    chk("R8 v_fporch", v_fporch, g_vf);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Scenario: both syncs active-high
        set_geom(4, 6, 20, 5, 2, 3, 10, 2, 1, 1);
        do_reset();
        @(negedge clk);
        chk("R1 valid", timing_valid, 0);
        chk("R1 h_active", h_active, 0);
        chk("R1 v_active", v_active, 0);
        chk("R1 h_sync", h_sync_w, 0);
        chk("R1 hs_pol", hs_pol, 0);
        chk("R1 vs_pol", vs_pol, 0);
        chk("R1 h_pos", h_pos, 0);
        chk("R1 v_pos", v_pos, 0);
        send_frame(); send_frame();
        @(negedge clk);
        chk("R9 no lock before two frames end", timing_valid, 0);
        send_frame();
        @(negedge clk);
        chk("R9 lock after two frames", timing_valid, 1);
        check_all("high/high");
        cmp_meas = 1;
        send_frame(); send_frame();

        // Scenario: geometry change while locked
        cmp_meas = 0;
        set_geom(3, 5, 16, 4, 3, 2, 8, 3, 1, 1);
        send_frame();
        @(negedge clk);
        chk("R9 still locked in changed frame", timing_valid, 1);
        chk("R8 h_active held until boundary", h_active, 20);
        chk("R8 v_active held until boundary", v_active, 10);
        send_frame();
        @(negedge clk);
        chk("R9 unlock after differing frame", timing_valid, 0);
        chk("R4 new h_active committed", h_active, 16);
        send_frame();
        @(negedge clk);
        chk("R9 relock", timing_valid, 1);
        check_all("changed");
        cmp_meas = 1;
        send_frame();

        // Scenario: sync outage saturates the pixel counter
        idle(4200);
        @(negedge clk);
        chk("R10 h_pos saturated", h_pos, 4095);
        chk("R10 valid cleared", timing_valid, 0);
        cmp_meas = 0;
        send_frame(); send_frame();
        @(negedge clk);
        chk("R9 no lock from saturated frame", timing_valid, 0);
        send_frame();
        @(negedge clk);
        chk("R9 lock after two clean frames", timing_valid, 1);
        check_all("after outage");

        // Scenario: both syncs active-low
        set_geom(3, 5, 16, 4, 3, 2, 8, 3, 0, 0);
        do_reset();
        @(negedge clk);
        chk("R1 valid after reset", timing_valid, 0);
        wait_lock(12);
        chk("R9 lock low/low", timing_valid, 1);
        check_all("low/low");
        cmp_meas = 1;
        send_frame(); send_frame();
        cmp_meas = 0;

        // Scenario: line sync active-low, frame sync active-high
        set_geom(6, 4, 24, 3, 1, 4, 12, 2, 0, 1);
        do_reset();
        wait_lock(12);
        chk("R9 lock low/high", timing_valid, 1);
        check_all("low/high");
        cmp_meas = 1;
        send_frame(); send_frame();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule